// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a flash device. A program or erase command has already been sent to the device. The block then works out when that operation has finished by reading one flash location over and over through a simple read port. It can use either of two methods, chosen at start:

- **Level method:** watch bit 7 until it equals the value it should have once the operation is done.
- **Toggle method:** watch bit 6 until two reads in a row give the same value.

Bit 5 of each status read is the device's error flag. When the error flag shows up before completion, the block makes one more read before it gives up. The completion bit can change in the same read that first shows the error.

After a program operation completes, the block reads the location one last time and compares the whole byte with the data that was meant to be written. The outcome is one `done` strobe that carries exactly one of `pass` or `fail`. A poll budget, set by a parameter, ends a run whose completion never arrives.

Top module: `flash_done_poller`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `rd_req`, `done`, `pass` and `fail` are all 0.
- R2: Every read is a one-cycle `rd_req` pulse with `rd_addr` equal to the `tgt_addr` latched at `start`. There is never more than one read outstanding. The next request is issued only after `rd_valid` has returned the previous read. `start` is accepted only while `busy` is 0.
- R3: With `use_toggle`=0 and `is_erase`=0, a status read is complete when its bit 7 equals bit 7 of `exp_data`.
- R4: With `is_erase`=1, the expected bit 7 is 1 whatever `exp_data` holds. A completed erase passes with no verify read.
- R5: With `use_toggle`=1, a status read is complete when its bit 6 equals bit 6 of the status read just before it in the same run. The first read of a run is never complete.
- R6: If a status read is not complete and its bit 5 is 1, exactly one more status read follows. If that read is complete, the run continues as a success. If it is not complete, the run fails.
- R7: If a status read is not complete, its bit 5 is 0, and the poll budget is not spent, another status read follows.
- R8: After a completed program, one verify read of the same address follows. The run passes only if all 8 bits equal `exp_data`.
- R9: A run fails after `MAX_POLLS` poll reads (recheck reads not counted) if none of them was complete and the last one had bit 5 at 0.
- R10: A run ends with `done` high for one cycle, with exactly one of `pass`/`fail` high in that cycle and neither high at any other time. `busy` is 1 from the cycle after `start` until `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a polling run (used only when idle) |
| use_toggle | input | 1 | 0 = level method on bit 7, 1 = toggle method on bit 6 |
| is_erase | input | 1 | 1 = erase operation, 0 = program operation |
| tgt_addr | input | ADDR_W | Location to poll and verify |
| exp_data | input | 8 | Byte that was programmed |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | End-of-run strobe |
| pass | output | 1 | Run succeeded (with done) |
| fail | output | 1 | Run failed (with done) |

## Verification
The assertions assume that the read port answers each request with exactly one `rd_valid` pulse, at least one cycle after the request, and never sends `rd_valid` when no read is pending. The bench's flash model keeps to this. It arms one response per request and has a latency of 1 to 3 cycles.

The model plays a scripted device. For busy reads it returns the complement of the expected bit 7 and a bit 6 that alternates between reads. The error flag can be set in one of two patterns: it stays set from a chosen read onward, or it shows only on the last busy read. The expected read count and outcome are worked out arithmetically for each case. `start` is raised only while the block is idle.

// File: rtl/fpoll_pkg.sv
// Package: shared types for the flash completion polling controller.
// Assumes: nothing beyond IEEE 1800-2017.
package fpoll_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2
    } fsm_t;

    typedef enum logic [1:0] {
        K_POLL    = 2'd0,
        K_RECHECK = 2'd1,
        K_VERIFY  = 2'd2
    } rkind_t;
endpackage

// File: rtl/fpoll_judge.sv
// Module: fpoll_judge
// Judges one returned byte: whether the status shows completion, whether the
// error flag (bit 5) is set, and whether a verify byte matches.
// Assumes: prev6/have_prev belong to the current run only.
module fpoll_judge (
    input  logic       toggle_mode,
    input  logic       erase_mode,
    input  logic [7:0] exp_byte,
    input  logic       have_prev,
    input  logic       prev6,
    input  logic [7:0] rd_byte,
    output logic       complete,
    output logic       err_flag,
    output logic       match
);
    logic want7;

    // Derive the completion condition for the selected method.
    always_comb begin
        want7    = erase_mode ? 1'b1 : exp_byte[7];
        if (toggle_mode)
            complete = have_prev && (prev6 == rd_byte[6]);
        else
            complete = (rd_byte[7] == want7);
        err_flag = rd_byte[5];
        match    = (rd_byte == exp_byte);
    end
endmodule

// File: rtl/fpoll_budget.sv
// Module: fpoll_budget
// Counts poll reads in a run and flags the read that uses up the budget.
// Assumes: clr and inc never assert together.
module fpoll_budget #(
    parameter int MAX_POLLS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt;

    // Poll read counter, cleared at the start of every run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // Flag the read that would be the final one allowed.
    always_comb last = (cnt == CW'(MAX_POLLS - 1));

    // R9: the controller stops counting once the budget is spent.
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_POLLS));
endmodule

// File: rtl/flash_done_poller.sv
// Module: flash_done_poller
// Host-side controller that polls a flash location until a program or erase
// completes (level method on bit 7 or toggle method on bit 6). It rechecks
// once after the error flag, verifies programmed bytes, and reports pass/fail.
// Assumes: one rd_valid pulse per rd_req, at least one cycle later.
module flash_done_poller
    import fpoll_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_POLLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              use_toggle,
    input  logic              is_erase,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        exp_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    fsm_t              state;
    rkind_t            kind;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        exp_q;
    logic              tog_q, ers_q, have_prev, prev6;
    logic              done_q, pass_q, fail_q;
    logic              complete, err_flag, match, last;
    logic              got, status_rd, poll_rd;

    fpoll_judge u_judge (
        .toggle_mode (tog_q),
        .erase_mode  (ers_q),
        .exp_byte    (exp_q),
        .have_prev   (have_prev),
        .prev6       (prev6),
        .rd_byte     (rd_data),
        .complete    (complete),
        .err_flag    (err_flag),
        .match       (match)
    );

    // Decode which read just returned.
    always_comb begin
        got       = (state == S_WAIT) && rd_valid;
        status_rd = got && (kind != K_VERIFY);
        poll_rd   = got && (kind == K_POLL);
    end

    fpoll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == S_IDLE),
        .inc   (poll_rd),
        .last  (last)
    );

    // Main sequencer: issue reads, judge each reply, finish the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            kind      <= K_POLL;
            addr_q    <= '0;
            exp_q     <= '0;
            tog_q     <= 1'b0;
            ers_q     <= 1'b0;
            have_prev <= 1'b0;
            prev6     <= 1'b0;
            done_q    <= 1'b0;
            pass_q    <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    addr_q    <= tgt_addr;
                    exp_q     <= exp_data;
                    tog_q     <= use_toggle;
                    ers_q     <= is_erase;
                    have_prev <= 1'b0;
                    kind      <= K_POLL;
                    state     <= S_REQ;
                end
                S_REQ: state <= S_WAIT;
                S_WAIT: if (rd_valid) begin
                    if (kind == K_VERIFY) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                        pass_q <= match;
                        fail_q <= !match;
                    end else begin
                        have_prev <= 1'b1;
                        prev6     <= rd_data[6];
                        if (complete) begin
                            if (ers_q) begin
                                state  <= S_IDLE;
                                done_q <= 1'b1;
                                pass_q <= 1'b1;
                            end else begin
                                kind  <= K_VERIFY;
                                state <= S_REQ;
                            end
                        end else if (kind == K_RECHECK || (!err_flag && last)) begin
                            state  <= S_IDLE;
                            done_q <= 1'b1;
                            fail_q <= 1'b1;
                        end else begin
                            if (err_flag)
                                kind <= K_RECHECK;
                            state <= S_REQ;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the port outputs from state.
    always_comb begin
        rd_req  = (state == S_REQ);
        rd_addr = addr_q;
        busy    = (state != S_IDLE);
        done    = done_q;
        pass    = pass_q;
        fail    = fail_q;
    end

    // R2: a request is a single-cycle pulse, never issued while waiting.
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R2: no request while idle.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);
    // R10: done carries exactly one verdict; a verdict never appears alone.
    a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({pass, fail}));
    a_r10_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(pass || fail));
    // R10: done is a single pulse.
    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: a recheck that is still not complete ends the run with fail.
    a_r6_recheck_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && kind == K_RECHECK && !complete) |=> (done && fail));
    // R8: the verify verdict follows the byte comparison.
    a_r8_verify: assert property (@(posedge clk) disable iff (!rst_n)
        (got && kind == K_VERIFY) |=> (done && (pass == $past(rd_data == exp_q))));
endmodule

// File: tb/tb_flash_done_poller.sv
// Bench: near-exhaustive sweep of methods, operations, busy lengths, latencies,
// error patterns and timeout against a scripted flash model.
module tb_flash_done_poller;
    localparam int AW  = 8;
    localparam int MAXP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, use_toggle = 1'b0, is_erase = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [7:0]    exp_data = '0;
    logic          rd_req, rd_valid = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = '0;
    logic          busy, done, pass, fail;

    int total = 0, bad = 0;
    int cyc = 0;

    // Flash model controls.
    int   m_busy, m_errfrom, m_lat, m_pend, m_reads, m_addrbad;
    logic m_race, m_erase;
    logic [7:0] m_final, m_exp;

    flash_done_poller #(.ADDR_W(AW), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .use_toggle(use_toggle),
        .is_erase(is_erase), .tgt_addr(tgt_addr), .exp_data(exp_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .done(done), .pass(pass), .fail(fail)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Byte returned on read number i of the run.
    function automatic logic [7:0] model_byte(int i);
        logic [7:0] v;
        logic       e7;
        v = m_erase ? 8'hFF : m_final;
        if (i >= m_busy) return v;
        e7 = m_erase ? 1'b1 : m_exp[7];
        model_byte = 8'h00;
        model_byte[7] = ~e7;
        model_byte[6] = v[6] ^ logic'((m_busy - i) % 2);
        model_byte[5] = m_race ? (i == m_busy - 1) : (m_errfrom >= 0 && i >= m_errfrom);
    endfunction

    // Flash model: one response per request after m_lat cycles.
    always @(negedge clk) begin
        rd_valid <= 1'b0;
        if (m_pend > 0) begin
            m_pend <= m_pend - 1;
            if (m_pend == 1) begin
                rd_valid <= 1'b1;
                rd_data  <= model_byte(m_reads);
                m_reads  <= m_reads + 1;
            end
        end
        if (rd_req) begin
            m_pend <= m_lat;
            if (rd_addr !== tgt_addr) m_addrbad <= m_addrbad + 1;
        end
    end

    task automatic check(string req, logic ok, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One run: returns after done or after a per-run watchdog.
    task automatic run(input logic tog, input logic ers, input logic [7:0] d,
                       input logic [7:0] f, input int busyn, input int errfrom,
                       input logic race, input int lat, input int exp_reads,
                       input logic exp_pass, input string req);
        int   w;
        int   dones;
        logic got_pass, got_fail;
        m_busy = busyn; m_errfrom = errfrom; m_race = race; m_lat = lat;
        m_erase = ers; m_final = f; m_exp = d;
        m_reads = 0; m_addrbad = 0; m_pend = 0;
        @(negedge clk);
        use_toggle = tog; is_erase = ers; exp_data = d;
        tgt_addr = AW'(8'h40 + busyn * 3 + lat);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", busy === 1'b1, int'(busy), 1);
        dones = 0; got_pass = 0; got_fail = 0;
        for (w = 0; w < 400; w++) begin
            @(negedge clk);
            if (done) begin
                dones++; got_pass = pass; got_fail = fail;
                break;
            end
        end
        check({req, " finished"}, dones == 1, dones, 1);
        check({req, " verdict"}, got_pass == exp_pass && got_fail == !exp_pass,
              int'({got_pass, got_fail}), int'({exp_pass, !exp_pass}));
        check({req, " read count"}, m_reads == exp_reads, m_reads, exp_reads);
        check("R2 address", m_addrbad == 0, m_addrbad, 0);
        @(negedge clk);
        check("R10 single pulse", done === 1'b0 && busy === 1'b0, int'(done), 0);
    endtask

    // Global watchdog.
    initial begin
        wait (cyc > 150000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_pend = 0; m_lat = 1; m_reads = 0; m_addrbad = 0;
        m_busy = 0; m_errfrom = -1; m_race = 0; m_erase = 0;
        m_final = 0; m_exp = 0;
        repeat (3) @(negedge clk);
        check("R1 reset", {busy, rd_req, done, pass, fail} === 5'b0,
              int'({busy, rd_req, done, pass, fail}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {busy, rd_req, done} === 3'b0,
              int'({busy, rd_req, done}), 0);

        // R3 R4 R5 R7 R8: normal completion sweep.
        for (int tg = 0; tg < 2; tg++)
            for (int er = 0; er < 2; er++)
                for (int b = 0; b < 5; b++)
                    for (int l = 1; l < 4; l++) begin
                        logic [7:0] d;
                        int st;
                        d  = er ? 8'h00 : ((b % 2) ? 8'hA5 : 8'h3C);
                        st = tg ? b + 2 : b + 1;
                        run(logic'(tg), logic'(er), d, d, b, -1, 1'b0, l,
                            er ? st : st + 1, 1'b1,
                            tg ? (er ? "R5 R4 toggle erase" : "R5 R8 toggle program")
                               : (er ? "R4 level erase" : "R3 R7 R8 level program"));
                    end

        // R8: verify mismatch in low bits.
        for (int tg = 0; tg < 2; tg++)
            for (int b = 0; b < 3; b++)
                run(logic'(tg), 1'b0, 8'hC3, 8'hC2, b, -1, 1'b0, 2,
                    (tg ? b + 2 : b + 1) + 1, 1'b0, "R8 verify mismatch");

        // R6: persistent error from read e, device never completes.
        for (int tg = 0; tg < 2; tg++)
            for (int er = 0; er < 2; er++)
                for (int e = 0; e < 4; e++)
                    run(logic'(tg), logic'(er), 8'h5A, 8'h5A, 1000, e, 1'b0, 1,
                        e + 2, 1'b0, "R6 hard error");

        // R6: error on last busy read; the recheck sees the finished state.
        for (int b = 1; b < 4; b++) begin
            run(1'b0, 1'b0, 8'h96, 8'h96, b, -1, 1'b1, 1, b + 2, 1'b1,
                "R6 race level program");
            run(1'b0, 1'b1, 8'h00, 8'h00, b, -1, 1'b1, 2, b + 1, 1'b1,
                "R6 race level erase");
            run(1'b1, 1'b0, 8'h96, 8'h96, b, -1, 1'b1, 1, b + 1, 1'b0,
                "R6 race toggle");
        end

        // R9: never completes, no error flag.
        for (int tg = 0; tg < 2; tg++)
            for (int er = 0; er < 2; er++)
                run(logic'(tg), logic'(er), 8'h81, 8'h81, 1000, -1, 1'b0, 1,
                    MAXP, 1'b0, "R9 poll budget");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule